// File: doc/BRIEF.md
# Calibration DAC serial loader

This block writes 8-bit trim codes into a bank of 21 calibration channels. The channels sit in three 8-channel converter chips that share one serial clock and one serial data line. The host offers a channel number and a byte on a valid/ready request port. For each accepted request the block sends an 11-bit word, most significant bit first. The upper three bits of the word are the in-chip address, which is the low three bits of the channel, and the lower eight bits are the value. After the last bit the block drives a 2-bit load-select code for one phase. The code is one more than the upper channel bits, so it is 1, 2 or 3, and it latches the word into the chip that owns the channel. The code then returns to zero.

The request port follows valid/ready rules. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole transfer, and this is the only back-pressure. A request offered while `req_ready` is low has no effect unless it is still held when `req_ready` returns high. The channel, value and phase length must stay stable while `req_valid` is high. Each serial clock phase lasts `phase_len` system cycles, and a value of 0 counts as 1. The length is captured when the request is accepted. A channel above 20 is refused with a one-cycle error pulse and causes no serial activity.

Top module: `cal_dac_loader`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A request is accepted only on a rising edge with `req_valid` and `req_ready` both high. A request shown while `busy` is high and withdrawn before `busy` falls produces no transfer.
- R2: A valid request sends exactly 11 bits, most significant first, one bit per rising edge of `ser_clk`. Bits 10:8 are `req_chan[2:0]` and bits 7:0 are `req_value`.
- R3: For each bit, `ser_data` is set while `ser_clk` is low for P cycles, then `ser_clk` is high for P cycles with `ser_data` held. P is the captured `phase_len`, with 0 treated as 1.
- R4: After the 11th high phase, `load_sel` equals `req_chan[4:3] + 1` for P cycles with `ser_clk` low, then returns to 0. Channels 0-7 give 1, channels 8-15 give 2, and channels 16-20 give 3.
- R5: `busy` rises in the cycle after acceptance and stays high for exactly 23·P cycles, through the last load-select cycle.
- R6: `done` is a one-cycle pulse in the first cycle after `busy` falls, and at no other time.
- R7: An accepted request with `req_chan` > 20 raises `err` for one cycle in the next cycle. `busy`, `ser_clk`, `load_sel` and `done` stay low.
- R8: Whenever `busy` is low, including after reset, `ser_clk`, `ser_data` and `load_sel` are 0. Out of reset `req_ready` is 1 and `done` and `err` are 0.
- R9: A change of `phase_len` while `busy` is high does not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_chan | input | 5 | Calibration channel, 0 to 20 valid |
| req_value | input | 8 | Trim value |
| phase_len | input | 8 | System cycles per serial phase, 0 treated as 1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused channel |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data |
| load_sel | output | 2 | Chip load-select code, 0 when idle |

## Verification
The assertions check several properties on every cycle. Data is held while the serial clock is high. The load-select code appears only with the clock low and only right after a high phase. The lines are quiet whenever the block is idle. `done` follows the fall of `busy` and nothing else, and a refusal never starts a transfer. Only the bench scenarios can show the rest, by decoding the serial stream against a queue of expected items. Those scenarios cover the bit content and order of each word, the chip code for each channel range, the exact phase and busy durations for several phase lengths (including 0), and the fact that requests offered during a transfer or after a mid-transfer phase change leave no trace.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } cdl_state_e;
endpackage

// File: rtl/cdl_phase_timer.sv
module cdl_phase_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [LEN_W-1:0] len,
  output logic             zero
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (reload) cnt_q <= len - LEN_W'(1);
    else             cnt_q <= cnt_q - LEN_W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cdl_shifter.sv
module cdl_shifter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= din;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/cal_dac_loader.sv
module cal_dac_loader #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int CHAN_W   = 5,
  parameter int NUM_CHAN = 21,
  parameter int LEN_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [CHAN_W-1:0]        req_chan,
  input  logic [DATA_W-1:0]        req_value,
  input  logic [LEN_W-1:0]         phase_len,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic                     ser_clk,
  output logic                     ser_data,
  output logic [CHAN_W-ADDR_W-1:0] load_sel
);
  import cdl_pkg::*;

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int SEL_W  = CHAN_W - ADDR_W;
  localparam int BIT_W  = $clog2(WORD_W);

  cdl_state_e       state_q;
  logic             phase_hi_q;
  logic [BIT_W-1:0] bits_q;
  logic [SEL_W-1:0] code_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q, err_q;

  logic [LEN_W-1:0] len_in;
  logic             accept, bad_chan, start;
  logic             tmr_zero, expire, do_shift, shift_msb;

  assign len_in   = (phase_len == '0) ? LEN_W'(1) : phase_len;
  assign req_ready = (state_q == ST_IDLE);
  assign accept   = req_valid && req_ready;
  assign bad_chan = (req_chan > CHAN_W'(NUM_CHAN - 1));
  assign start    = accept && !bad_chan;
  assign expire   = (state_q != ST_IDLE) && tmr_zero;
  assign do_shift = (state_q == ST_SHIFT) && expire && phase_hi_q;

  cdl_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload ((state_q == ST_IDLE) || expire),
    .len    ((state_q == ST_IDLE) ? len_in : len_q),
    .zero   (tmr_zero)
  );

  cdl_shifter #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .din   ({req_chan[ADDR_W-1:0], req_value}),
    .shift (do_shift),
    .msb   (shift_msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      phase_hi_q <= 1'b0;
      bits_q     <= '0;
      code_q     <= '0;
      len_q      <= LEN_W'(1);
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= accept && bad_chan;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_SHIFT;
            phase_hi_q <= 1'b0;
            bits_q     <= '0;
            code_q     <= req_chan[CHAN_W-1:ADDR_W] + SEL_W'(1);
            len_q      <= len_in;
          end
        end
        ST_SHIFT: begin
          if (expire) begin
            if (!phase_hi_q) begin
              phase_hi_q <= 1'b1;
            end else begin
              phase_hi_q <= 1'b0;
              bits_q     <= bits_q + BIT_W'(1);
              if (bits_q == BIT_W'(WORD_W - 1)) state_q <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (expire) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign ser_clk  = (state_q == ST_SHIFT) && phase_hi_q;
  assign ser_data = (state_q == ST_SHIFT) && shift_msb;
  assign load_sel = (state_q == ST_LOAD) ? code_q : '0;

  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  a_r4_load_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel != '0) |-> (!ser_clk && busy));

  a_r4_load_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|load_sel) |-> $past(ser_clk));

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  a_r6_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r7_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_data && load_sel == '0));
endmodule

// File: tb/cal_dac_loader_test.sv
module cal_dac_loader_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [4:0] req_chan;
  logic [7:0] req_value;
  logic [7:0] phase_len;
  logic       busy, done, err, ser_clk, ser_data;
  logic [1:0] load_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_dac_loader uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_value(req_value), .phase_len(phase_len),
    .busy(busy), .done(done), .err(err), .ser_clk(ser_clk),
    .ser_data(ser_data), .load_sel(load_sel)
  );

  typedef struct {
    logic [10:0] word;
    logic [1:0]  code;
    int          p;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  exp_t        cur;
  bit          have_cur;
  logic [10:0] got_word;
  int          nbits, run, bcyc;
  bit          phase_bad, idle_bad, prev_busy;
  logic [1:0]  code_seen;
  logic [3:0]  prev_tup;
  logic [3:0]  tup;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_tup = '0; prev_busy = 0; run = 0; idle_bad = 0; have_cur = 0;
    end else begin
      tup = {busy, ser_clk, load_sel};
      if (!busy && (ser_clk || ser_data || load_sel != 0)) idle_bad = 1;
      if (busy && !prev_busy) begin
        have_cur = (q.size() > 0);
        if (have_cur) cur = q[0];
        got_word = '0; nbits = 0; bcyc = 0; phase_bad = 0; code_seen = 0;
      end
      if (busy) bcyc++;
      if (tup != prev_tup) begin
        if (prev_tup[3] && have_cur && run != cur.p) phase_bad = 1;
        if (ser_clk && !prev_tup[2]) begin
          got_word = {got_word[9:0], ser_data};
          nbits++;
        end
        if (load_sel != 0 && prev_tup[1:0] == 0) code_seen = load_sel;
        run = 1;
      end else begin
        run++;
      end
      if (done) begin
        if (!have_cur || q.size() == 0) begin
          check(0, "R6 done without accepted request", 1, 0);
        end else begin
          void'(q.pop_front());
          check(prev_busy && !busy, "R6 done timing", int'(prev_busy), 1);
          check(nbits == 11, "R2 bit count", nbits, 11);
          check(got_word == cur.word, "R2 word", int'(got_word), int'(cur.word));
          check(code_seen == cur.code, "R4 load code", int'(code_seen), int'(cur.code));
          check(bcyc == 23 * cur.p, "R5 busy length", bcyc, 23 * cur.p);
          check(!phase_bad, "R3 phase lengths", int'(phase_bad), 0);
        end
        have_cur = 0;
      end
      prev_tup  = tup;
      prev_busy = busy;
    end
  end

  task automatic send(int c, int v, int p, bit rej);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1; req_chan = 5'(c); req_value = 8'(v); phase_len = 8'(p);
    @(posedge clk);
    if (!rej) begin
      e.word = {3'(c & 7), 8'(v)};
      e.code = 2'((c >> 3) + 1);
      e.p    = (p == 0) ? 1 : p;
      q.push_back(e);
    end
    #1 req_valid = 0;
    @(negedge clk);
    if (rej) begin
      check(err == 1, "R7 err pulse", int'(err), 1);
      check(busy == 0, "R7 no busy", int'(busy), 0);
    end else begin
      check(busy == 1 && req_ready == 0, "R5 busy rise / R1 ready low", int'(busy), 1);
    end
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_chan = 0; req_value = 0; phase_len = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1, "R8 reset ready", int'(req_ready), 1);
    check(busy == 0 && done == 0 && err == 0, "R8 reset flags", int'({busy, done, err}), 0);
    check(ser_clk == 0 && ser_data == 0 && load_sel == 0, "R8 reset lines",
          int'({ser_clk, ser_data, load_sel}), 0);
    @(posedge clk); #1 rst_n = 1;

    send(0,  8'hA5, 1, 0); wait_quiet();
    send(7,  8'h3C, 2, 0); wait_quiet();
    send(8,  8'h01, 3, 0); wait_quiet();
    send(15, 8'hC3, 1, 0); wait_quiet();
    send(16, 8'hFF, 2, 0); wait_quiet();
    send(20, 8'h80, 0, 0); wait_quiet();

    // R7: refused channels
    send(21, 8'h55, 1, 1);
    repeat (5) @(negedge clk);
    check(!busy && !ser_clk && !done, "R7 no activity after refusal",
          int'({busy, ser_clk, done}), 0);
    send(31, 8'hAA, 2, 1);
    repeat (5) @(negedge clk);

    // R9: phase length changed mid transfer
    send(10, 8'h5A, 4, 0);
    repeat (10) @(posedge clk);
    #1 phase_len = 8'd1;
    // R1: request offered while busy, withdrawn before busy falls
    req_chan = 5'd3; req_value = 8'h77; req_valid = 1;
    repeat (20) @(posedge clk);
    #1 req_valid = 0;
    wait_quiet();
    check(q.size() == 0, "R1/R9 all expected transfers seen", q.size(), 0);

    send(19, 8'h0F, 1, 0); wait_quiet();
    check(idle_bad == 0, "R8 idle lines quiet", int'(idle_bad), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule